// File: doc/BRIEF.md
# Configurable Population Count Unit

This block reports how many bits of an input vector are set to one. The vector width is a build-time parameter, and the count output is just wide enough to hold the value for an all-ones input. A second build-time switch chooses how the count is produced. The port list is the same for both choices, so a parent design can change variants without rewiring.

In the flat variant, a balanced adder tree sums the bits in one cycle and a register captures the total on every clock. The start strobe has no effect in this variant and ready stays high. In the iterative variant, a start request is accepted only while ready is high. The vector is copied into an internal shift register, and one bit is added per clock, so each operation takes one cycle per input bit. The previous result stays on the output until the new total is complete. At that point ready rises again.

Top module: `bitcount_unit`

## Requirements
- R1: When a count is presented, count_o equals the number of one bits in the vector it was computed from. count_o is ceil(log2(WIDTH+1)) bits wide, so an all-ones vector gives count_o = WIDTH.
- R2: While reset is asserted, and in the first cycle after it, count_o is 0 and ready_o is 1 in both variants.
- R3: In the flat variant (ITERATIVE = 0), count_o after each rising clock edge equals the popcount of vec_i sampled at that edge, whatever the value of start_i.
- R4: In the flat variant, ready_o is 1 in every cycle.
- R5: In the iterative variant (ITERATIVE = 1), start_i = 1 sampled while ready_o = 1 captures vec_i, and ready_o is 0 from the next cycle.
- R6: In the iterative variant, after an accepted start, ready_o stays 0 for exactly WIDTH clock cycles and then returns to 1 with the new result on count_o.
- R7: In the iterative variant, count_o keeps its previous value while ready_o is 0. It changes only in the cycle in which ready_o returns to 1.
- R8: In the iterative variant, start_i = 1 while ready_o = 0 is ignored. This includes the final busy cycle. The result and the busy length are those of the accepted request.
- R9: In the iterative variant, changes on vec_i after the start has been accepted do not affect the result.
- R10: In the iterative variant, a start given in the first cycle in which ready_o is back at 1 is accepted, so operations can follow each other with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Operation request. Used only by the iterative variant |
| vec_i | input | WIDTH | Vector whose one bits are counted |
| count_o | output | ceil(log2(WIDTH+1)) | Registered count of one bits |
| ready_o | output | 1 | High when idle and able to accept a start. Always high in the flat variant |

## Verification
In the iterative variant, the completion of an operation and a new start request can reach the clock edge in the same cycle. The bench provokes this in two ways. First, it raises start_i in the last busy cycle, when the final bit is being added. That request must be dropped: the finished count must belong to the first vector, and the next busy window must not begin. Second, it raises start_i in the very cycle that ready_o returns high. That request must be taken at once, while the count just finished stays on the output for the whole following busy window. Both cases are judged at the ports by the number of cycles that ready_o stays low and by the value and stability of count_o.

// File: rtl/bitcount_pkg.sv
package bitcount_pkg;

    typedef enum logic {
        BC_IDLE = 1'b0,
        BC_BUSY = 1'b1
    } bc_mode_e;

    function automatic int unsigned bc_count_width(input int unsigned w);
        return $clog2(w + 1);
    endfunction

endpackage

// File: rtl/bc_popcount_tree.sv
module bc_popcount_tree
    import bitcount_pkg::*;
#(
    parameter int unsigned WIDTH = 16,
    parameter int unsigned CW    = bc_count_width(WIDTH)
) (
    input  logic [WIDTH-1:0] vec_i,
    output logic [CW-1:0]    sum_o
);
    localparam int unsigned LEVELS = (WIDTH > 1) ? $clog2(WIDTH) : 0;
    localparam int unsigned LEAVES = 1 << LEVELS;
    localparam int unsigned NODES  = 2 * LEAVES - 1;

    // heap layout: node k has children 2k+1 and 2k+2, leaves at the tail
    logic [CW-1:0] node [NODES];

    genvar gi;
    generate
        for (gi = 0; gi < LEAVES; gi++) begin : g_leaf
            if (gi < WIDTH) begin : g_real
                assign node[LEAVES-1+gi] = CW'(vec_i[gi]);
            end else begin : g_pad
                assign node[LEAVES-1+gi] = '0;
            end
        end
        for (gi = 0; gi < LEAVES - 1; gi++) begin : g_sum
            assign node[gi] = node[2*gi+1] + node[2*gi+2];
        end
    endgenerate

    assign sum_o = node[0];

endmodule

// File: rtl/bc_flat_stage.sv
module bc_flat_stage
    import bitcount_pkg::*;
#(
    parameter int unsigned WIDTH = 16,
    parameter int unsigned CW    = bc_count_width(WIDTH)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] vec_i,
    output logic [CW-1:0]    count_o
);
    typedef struct packed {
        logic [CW-1:0] count;
    } flat_st_t;

    flat_st_t      st_d, st_q;
    logic [CW-1:0] tree_sum;

    bc_popcount_tree #(
        .WIDTH (WIDTH),
        .CW    (CW)
    ) u_tree (
        .vec_i (vec_i),
        .sum_o (tree_sum)
    );

    always_comb begin
        st_d       = st_q;
        st_d.count = tree_sum;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.count;

endmodule

// File: rtl/bc_iter_engine.sv
module bc_iter_engine
    import bitcount_pkg::*;
#(
    parameter int unsigned WIDTH = 16,
    parameter int unsigned CW    = bc_count_width(WIDTH)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic [WIDTH-1:0] vec_i,
    output logic [CW-1:0]    count_o,
    output logic             ready_o
);
    localparam int unsigned LW = $clog2(WIDTH + 1);

    typedef struct packed {
        bc_mode_e         mode;
        logic [WIDTH-1:0] shift;
        logic [CW-1:0]    acc;
        logic [LW-1:0]    left;
        logic [CW-1:0]    result;
    } iter_st_t;

    iter_st_t      st_d, st_q;
    logic [CW-1:0] acc_next;

    assign acc_next = st_q.acc + CW'(st_q.shift[0]);

    always_comb begin
        st_d = st_q;
        unique case (st_q.mode)
            BC_IDLE: begin
                if (start_i) begin
                    st_d.mode  = BC_BUSY;
                    st_d.shift = vec_i;
                    st_d.acc   = '0;
                    st_d.left  = LW'(WIDTH);
                end
            end
            BC_BUSY: begin
                st_d.acc   = acc_next;
                st_d.shift = st_q.shift >> 1;
                st_d.left  = st_q.left - 1'b1;
                if (st_q.left == LW'(1)) begin
                    st_d.result = acc_next;
                    st_d.mode   = BC_IDLE;
                end
            end
            default: st_d.mode = BC_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{mode: BC_IDLE, shift: '0, acc: '0, left: '0, result: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.result;
    assign ready_o = (st_q.mode == BC_IDLE);

endmodule

// File: rtl/bitcount_unit.sv
module bitcount_unit
    import bitcount_pkg::*;
#(
    parameter int unsigned WIDTH     = 16,
    parameter bit          ITERATIVE = 1'b1,
    localparam int unsigned CW       = bc_count_width(WIDTH)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic [WIDTH-1:0] vec_i,
    output logic [CW-1:0]    count_o,
    output logic             ready_o
);
    generate
        if (ITERATIVE) begin : g_iter
            bc_iter_engine #(
                .WIDTH   (WIDTH),
                .CW      (CW)
            ) u_engine (
                .clk_i   (clk_i),
                .rst_ni  (rst_ni),
                .start_i (start_i),
                .vec_i   (vec_i),
                .count_o (count_o),
                .ready_o (ready_o)
            );
        end else begin : g_flat
            bc_flat_stage #(
                .WIDTH   (WIDTH),
                .CW      (CW)
            ) u_stage (
                .clk_i   (clk_i),
                .rst_ni  (rst_ni),
                .vec_i   (vec_i),
                .count_o (count_o)
            );
            assign ready_o = 1'b1;
        end
    endgenerate

endmodule

// File: rtl/bitcount_unit_chk.sv
module bitcount_unit_chk
    import bitcount_pkg::*;
#(
    parameter int unsigned WIDTH     = 16,
    parameter bit          ITERATIVE = 1'b1,
    localparam int unsigned CW       = bc_count_width(WIDTH)
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             start_i,
    input logic [WIDTH-1:0] vec_i,
    input logic [CW-1:0]    count_o,
    input logic             ready_o
);
    generate
        if (ITERATIVE) begin : g_iter
            logic [CW:0]   low_q;
            logic [CW-1:0] ref_q;

            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) begin
                    low_q <= '0;
                    ref_q <= '0;
                end else begin
                    if (ready_o) begin
                        low_q <= '0;
                    end else begin
                        low_q <= low_q + 1'b1;
                    end
                    if (ready_o && start_i) begin
                        ref_q <= CW'($countones(vec_i));
                    end
                end
            end

            AST_START_DROPS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (ready_o && start_i) |=> !ready_o); // R5
            AST_BUSY_LENGTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
                $rose(ready_o) |-> (low_q == (CW+1)'(WIDTH))); // R6
            AST_COUNT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
                !$stable(count_o) |-> $rose(ready_o)); // R7
            AST_RESULT_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
                $rose(ready_o) |-> (count_o == ref_q)); // R1
        end else begin : g_flat
            AST_FLAT_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
                $past(rst_ni) |-> (count_o == CW'($countones($past(vec_i))))); // R3
        end
    endgenerate

endmodule

bind bitcount_unit bitcount_unit_chk #(
    .WIDTH     (WIDTH),
    .ITERATIVE (ITERATIVE)
) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .vec_i   (vec_i),
    .count_o (count_o),
    .ready_o (ready_o)
);

// File: tb/bitcount_unit_tb_top.sv
module bitcount_unit_tb_top;
    localparam int unsigned IW  = 16;
    localparam int unsigned ICW = $clog2(IW + 1);
    localparam int unsigned FW  = 13;
    localparam int unsigned FCW = $clog2(FW + 1);

    logic           clk_i = 1'b0;
    logic           rst_ni = 1'b0;
    logic           start_i = 1'b0;
    logic [IW-1:0]  vec_i = '0;
    logic [ICW-1:0] count_o;
    logic           ready_o;
    logic           start_c = 1'b0;
    logic [FW-1:0]  vec_c = '0;
    logic [FCW-1:0] count_c;
    logic           ready_c;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk_i = ~clk_i;

    bitcount_unit #(.WIDTH(IW), .ITERATIVE(1'b1)) dut_i (
        .clk_i (clk_i), .rst_ni (rst_ni), .start_i (start_i),
        .vec_i (vec_i), .count_o (count_o), .ready_o (ready_o)
    );

    bitcount_unit #(.WIDTH(FW), .ITERATIVE(1'b0)) dut_c_i (
        .clk_i (clk_i), .rst_ni (rst_ni), .start_i (start_c),
        .vec_i (vec_c), .count_o (count_c), .ready_o (ready_c)
    );

    function automatic int ones(input logic [31:0] v, input int w);
        int n = 0;
        for (int i = 0; i < w; i++) n += int'(v[i]);
        return n;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk_i);
        #1;
    endtask

    task automatic t_reset();
        rst_ni = 1'b0;
        repeat (3) tick();
        check("R2 iter count in reset", int'(count_o), 0);
        check("R2 iter ready in reset", int'(ready_o), 1);
        check("R2 flat count in reset", int'(count_c), 0);
        check("R2 flat ready in reset", int'(ready_c), 1);
        rst_ni = 1'b1;
        tick();
        check("R2 iter count after reset", int'(count_o), 0);
        check("R2 iter ready after reset", int'(ready_o), 1);
    endtask

    task automatic t_flat(input logic [FW-1:0] v, input logic st);
        int prev;
        prev    = int'(count_c);
        vec_c   = v;
        start_c = st;
        #1;
        check("R3 flat count before edge", int'(count_c), prev);
        tick();
        check("R3 flat count", int'(count_c), ones(32'(v), FW));
        check("R4 flat ready", int'(ready_c), 1);
    endtask

    // mode 0 plain, 1 start mid-busy, 2 vec changes while busy, 3 start in last busy cycle
    task automatic t_iter(input logic [IW-1:0] v, input int mode);
        int prev;
        int n;
        check("R10 ready before start", int'(ready_o), 1);
        prev    = int'(count_o);
        vec_i   = v;
        start_i = 1'b1;
        tick();
        start_i = 1'b0;
        check("R5 ready dropped", int'(ready_o), 0);
        n = 0;
        while (!ready_o && n < 4 * IW) begin
            check("R7 count held while busy", int'(count_o), prev);
            if (mode == 1 && n == IW / 2) begin
                start_i = 1'b1;
                vec_i   = ~v;
            end
            if (mode == 2) vec_i = ~vec_i;
            if (mode == 3 && n == IW - 1) begin
                start_i = 1'b1;
                vec_i   = ~v;
            end
            tick();
            start_i = 1'b0;
            n++;
        end
        check("R6 busy length", n, IW);
        check("R1 iter result", int'(count_o), ones(32'(v), IW));
        if (mode == 1) check("R8 ignored start mid-busy", int'(count_o), ones(32'(v), IW));
        if (mode == 2) check("R9 busy vec change ignored", int'(count_o), ones(32'(v), IW));
        if (mode == 3) begin
            tick();
            check("R8 last-cycle start ignored", int'(ready_o), 1);
            check("R8 count after last-cycle start", int'(count_o), ones(32'(v), IW));
        end
    endtask

    initial begin
        t_reset();
        t_flat(13'h0000, 1'b0);
        t_flat(13'h1FFF, 1'b1);
        t_flat(13'h1555, 1'b0);
        t_flat(13'h1000, 1'b1);
        t_flat(13'h0AAA, 1'b1);
        t_iter(16'h0000, 0);
        t_iter(16'hFFFF, 0);
        t_iter(16'hA5A5, 1);
        t_iter(16'h8000, 2);
        t_iter(16'h0001, 3);
        t_iter(16'h7E3C, 0);
        t_iter(16'hFFFE, 0);
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule